// File: doc/BRIEF.md
# Round-Robin TDM Slot Scheduler

This block decides, for every sample slot of an outgoing link, which buffer channel is allowed to send. It walks a list of rule indices in round-robin order, from index 0 up to a programmed last index. Each index is translated through a per-link lookup table into a buffer channel number and a transfer-mode flag. At the end of every pass it inserts a programmable run of idle bubble slots, each one sample long, and then starts the next pass at index 0.

A slot strobe asks for one decision. The answer appears on the outputs one clock later, as a single-cycle result. A frame restart puts the walk back at its start. The table is loaded through a one-entry-per-cycle write port. Each entry holds a channel number, a mode flag and an enable bit; a disabled entry turns its slot into an idle slot.

Top module: `tdm_slot_sched`

## Requirements
- R1: While reset is asserted and after it is released, no result is shown (`out_vld_o`=0, `out_idle_o`=0, `out_chan_o`=0, `out_pkt_o`=0). Every table entry starts out disabled, and the walk starts at rule index 0 with no bubble pending.
- R2: A cycle with `slot_i`=1 and `restart_i`=0 produces exactly one result in the next cycle: `out_vld_o`=1 or `out_idle_o`=1, never both. A cycle without such a strobe leaves both flags low in the next cycle. Whenever `out_vld_o`=0, `out_chan_o` and `out_pkt_o` are 0.
- R3: Slots that are not bubble slots take rule indices 0, 1, ..., L in order, where L=`rule_last_i` (0 to 127, so up to 128 rules). The index moves only on a slot and wraps to 0 after L.
- R4: After the slot for index L, the next `bubble_len_i`=B slots (1 to 255) are bubble slots, each with `out_vld_o`=0 and `out_idle_o`=1. The slot after the last bubble slot uses index 0.
- R5: With B=0 the slot after index L uses index 0 directly, with no idle slot in between.
- R6: The table has 128 entries. When `tbl_we_i`=1 the entry at `tbl_addr_i` takes `tbl_chan_i`, `tbl_pkt_i` and `tbl_en_i` at the clock edge. A non-bubble slot with an enabled entry shows `out_vld_o`=1 and that entry's channel on `out_chan_o`, together with its mode on `out_pkt_o` (1 = packet, 0 = circuit). A slot whose index is written in the same cycle uses the entry's previous contents.
- R7: A non-bubble slot whose entry is disabled gives `out_idle_o`=1, `out_vld_o`=0 and channel 0. The rule index still advances past it.
- R8: `restart_i`=1 returns the walk to index 0 and clears any pending bubble. A slot strobe in the same cycle is discarded, so the next cycle shows no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | Request for one slot decision |
| restart_i | input | 1 | Frame restart: back to index 0, bubble cleared |
| rule_last_i | input | 7 | Last rule index of a pass (rule count minus one) |
| bubble_len_i | input | 8 | Number of idle slots after each pass |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 7 | Table entry to write |
| tbl_chan_i | input | 7 | Buffer channel for the entry |
| tbl_pkt_i | input | 1 | Mode for the entry: 1 packet, 0 circuit |
| tbl_en_i | input | 1 | Entry enable |
| out_vld_o | output | 1 | Slot granted to `out_chan_o` |
| out_idle_o | output | 1 | Slot is idle (bubble or disabled entry) |
| out_chan_o | output | 7 | Granted buffer channel |
| out_pkt_o | output | 1 | Mode of the granted channel |

## Verification
Short passes of four rules are run with bubbles of zero and two slots. These separate a correct wrap from an off-by-one in the bubble count, and show a missing or extra idle slot. A full pass of 128 rules exercises the wrap of the 7-bit index, and a pattern of disabled entries shows that idle slots do not stall the index. Restarts are placed both mid-pass and inside a bubble, with a strobe in the same cycle, to show that the bubble is cleared and the strobe is dropped. Randomly spaced strobes then mix with table rewrites, changes of rule count and bubble length, and rare restarts, all against a bench model of the walk.

// File: rtl/tdm_slot_sched.sv
module tdm_slot_sched #(
  parameter int NRULE = 128,
  parameter int CHW   = 7,
  parameter int BUBW  = 8,
  localparam int IW   = $clog2(NRULE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_i,
  input  logic            restart_i,
  input  logic [IW-1:0]   rule_last_i,
  input  logic [BUBW-1:0] bubble_len_i,
  input  logic            tbl_we_i,
  input  logic [IW-1:0]   tbl_addr_i,
  input  logic [CHW-1:0]  tbl_chan_i,
  input  logic            tbl_pkt_i,
  input  logic            tbl_en_i,
  output logic            out_vld_o,
  output logic            out_idle_o,
  output logic [CHW-1:0]  out_chan_o,
  output logic            out_pkt_o
);

  logic [CHW+1:0]  tbl [NRULE];
  logic [IW-1:0]   idx;
  logic [BUBW-1:0] bcnt;
  logic            in_bub;
  logic [CHW+1:0]  ent;
  logic            ent_en, at_last, bub_end;

  assign ent     = tbl[idx];
  assign ent_en  = ent[CHW+1];
  assign at_last = (idx == rule_last_i);
  assign bub_end = (bcnt == bubble_len_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRULE; i++) tbl[i] <= '0;
    end else if (tbl_we_i) begin
      tbl[tbl_addr_i] <= {tbl_en_i, tbl_pkt_i, tbl_chan_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      bcnt       <= '0;
      in_bub     <= 1'b0;
      out_vld_o  <= 1'b0;
      out_idle_o <= 1'b0;
      out_chan_o <= '0;
      out_pkt_o  <= 1'b0;
    end else begin
      out_vld_o  <= 1'b0;
      out_idle_o <= 1'b0;
      out_chan_o <= '0;
      out_pkt_o  <= 1'b0;
      if (restart_i) begin
        idx    <= '0;
        bcnt   <= '0;
        in_bub <= 1'b0;
      end else if (slot_i) begin
        if (in_bub) begin
          out_idle_o <= 1'b1;
          if (bub_end) begin
            in_bub <= 1'b0;
            bcnt   <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          out_vld_o  <= ent_en;
          out_idle_o <= !ent_en;
          out_chan_o <= ent_en ? ent[CHW-1:0] : '0;
          out_pkt_o  <= ent_en & ent[CHW];
          if (at_last) begin
            idx    <= '0;
            in_bub <= (bubble_len_i != '0);
            bcnt   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

endmodule

module tdm_slot_sched_chk #(
  parameter int CHW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           slot_i,
  input logic           restart_i,
  input logic           out_vld_o,
  input logic           out_idle_o,
  input logic [CHW-1:0] out_chan_o,
  input logic           out_pkt_o
);

  // R2
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld_o && out_idle_o));

  // R2
  result_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !restart_i) |=> (out_vld_o || out_idle_o));

  // R2
  no_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> (!out_vld_o && !out_idle_o));

  // R8
  restart_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!out_vld_o && !out_idle_o));

  // R2
  idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld_o |-> (out_chan_o == '0 && !out_pkt_o));

endmodule

bind tdm_slot_sched tdm_slot_sched_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .restart_i(restart_i),
  .out_vld_o(out_vld_o), .out_idle_o(out_idle_o),
  .out_chan_o(out_chan_o), .out_pkt_o(out_pkt_o)
);

// File: tb/tdm_slot_sched_bench.sv
module tdm_slot_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRULE = 128;
  localparam int CHW   = 7;
  localparam int BUBW  = 8;
  localparam int IW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_i = 1'b0, restart_i = 1'b0, tbl_we_i = 1'b0;
  logic [IW-1:0] rule_last_i = '0, tbl_addr_i = '0;
  logic [BUBW-1:0] bubble_len_i = '0;
  logic [CHW-1:0] tbl_chan_i = '0;
  logic tbl_pkt_i = 1'b0, tbl_en_i = 1'b0;
  logic out_vld_o, out_idle_o, out_pkt_o;
  logic [CHW-1:0] out_chan_o;

  tdm_slot_sched u_tdm_slot_sched (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_ch [NRULE];
  bit m_pk [NRULE];
  bit m_en [NRULE];
  int m_idx = 0, m_bcnt = 0;
  bit m_inbub = 1'b0;
  bit e_vld = 0, e_idle = 0, e_pk = 0;
  int e_ch = 0;

  task automatic check_out();
    checks++;
    if (out_vld_o !== e_vld || out_idle_o !== e_idle ||
        int'(out_chan_o) != e_ch || out_pkt_o !== e_pk) begin
      errors++;
      $display("FAIL %s: vld/idle/chan/pkt = %0b/%0b/%0d/%0b expected %0b/%0b/%0d/%0b",
               cur_req, out_vld_o, out_idle_o, out_chan_o, out_pkt_o,
               e_vld, e_idle, e_ch, e_pk);
    end
  endtask

  task automatic step(bit s, bit r, bit we = 0, int a = 0, int ch = 0,
                      bit pk = 0, bit en = 0);
    @(negedge clk);
    check_out();
    slot_i = s; restart_i = r; tbl_we_i = we;
    tbl_addr_i = a[IW-1:0]; tbl_chan_i = ch[CHW-1:0];
    tbl_pkt_i = pk; tbl_en_i = en;
    e_vld = 0; e_idle = 0; e_ch = 0; e_pk = 0;
    if (!rst_n) begin
    end else if (r) begin
      m_idx = 0; m_bcnt = 0; m_inbub = 0;
    end else if (s) begin
      if (m_inbub) begin
        e_idle = 1;
        if (m_bcnt == ((int'(bubble_len_i) - 1) & 255)) begin
          m_inbub = 0; m_bcnt = 0;
        end else m_bcnt = (m_bcnt + 1) % 256;
      end else begin
        e_vld = m_en[m_idx]; e_idle = !m_en[m_idx];
        e_ch = m_en[m_idx] ? m_ch[m_idx] : 0;
        e_pk = m_en[m_idx] & m_pk[m_idx];
        if (m_idx == int'(rule_last_i)) begin
          m_idx = 0; m_inbub = (bubble_len_i != 0); m_bcnt = 0;
        end else m_idx = (m_idx + 1) % NRULE;
      end
    end
    if (we && rst_n) begin
      m_ch[a] = ch % 128; m_pk[a] = pk; m_en[a] = en;
    end
  endtask

  task automatic wr(int a, int ch, bit pk, bit en);
    step(0, 0, 1, a, ch, pk, en);
  endtask

  task automatic slots(int n);
    for (int i = 0; i < n; i++) step(1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NRULE; i++) begin m_ch[i] = 0; m_pk[i] = 0; m_en[i] = 0; end
    // R1: outputs quiet during reset
    cur_req = "R1";
    rule_last_i = 7'd3; bubble_len_i = 8'd0;
    step(1, 0); step(1, 0); step(0, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: entries start disabled -> every slot idle
    slots(4); step(0, 0);
    // R6: load four entries
    cur_req = "R6";
    for (int i = 0; i < 4; i++) wr(i, 10 + i * 7, i[0], 1'b1);
    step(0, 1);
    slots(4);
    // R3: in order with gaps between strobes
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin step(1, 0); step(0, 0); end
    // R4: bubble of two
    cur_req = "R4";
    step(0, 1);
    bubble_len_i = 8'd2;
    slots(14);
    // R5: no bubble
    cur_req = "R5";
    step(0, 1);
    bubble_len_i = 8'd0;
    slots(9);
    // R7: disabled entry still advances
    cur_req = "R7";
    wr(2, 55, 1'b1, 1'b0);
    step(0, 1);
    slots(8);
    // R6: same-cycle write of the slot's entry uses old contents
    cur_req = "R6";
    step(0, 1);
    step(1, 0, 1, 0, 99, 1'b0, 1'b1);
    slots(4);
    // R8: restart mid pass with a strobe, then inside a bubble
    cur_req = "R8";
    slots(2); step(1, 1); slots(3);
    bubble_len_i = 8'd3;
    step(0, 1); slots(5); step(1, 1); slots(6);
    // R3: full 128-rule pass with 7-bit wrap
    cur_req = "R3";
    for (int i = 0; i < NRULE; i++) wr(i, (i * 5 + 3) % 128, (i % 3) == 0, (i % 9) != 4);
    rule_last_i = 7'd127; bubble_len_i = 8'd1;
    step(0, 1);
    slots(260);
    // R2: random mix against the model
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 300 == 0) rule_last_i = 7'($urandom % 128);
      if ($urandom % 300 == 0) bubble_len_i = 8'($urandom % 6);
      if ($urandom % 15 == 0)
        step($urandom % 10 < 6, $urandom % 200 == 0, 1, int'($urandom % 128),
             int'($urandom % 128), 1'($urandom), ($urandom % 4) != 0);
      else
        step($urandom % 10 < 6, $urandom % 200 == 0);
    end
    step(0, 0); step(0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule